// File: doc/BRIEF.md
# Semi-Transparent Pixel Write Stage

This block is the final write stage for a frame buffer that stores 16-bit 5:5:5 pixels. Each request carries a target address, a foreground pixel and a set of control flags. The foreground is either a flat drawing color or a sampled texel that carries a mask bit. When semi-transparency is on, the stage first fetches the background pixel at the target address. It then mixes the background and foreground channel by channel, using one of four fixed blend modes. The mixing is done on values widened to 8 bits, and the result is narrowed back to 5 bits.

After mixing, the stage applies the mask rules. Bit 15 of the written word comes from the texel's own mask bit, and an optional forced-mask flag can also set it. An optional protect flag blocks the write whenever the stored pixel is already marked. Requests enter through a valid/ready handshake. The stage drives a single synchronous memory port, so read data appears one cycle after the read strobe. Only one request is in flight at a time, and each request takes a fixed four cycles from acceptance to the next ready.

Top module: `pix_blend_wr`

## Requirements
- R1: A pixel word holds red in bits 4:0, green in bits 9:5, blue in bits 14:10 and the mask flag in bit 15; the three color fields are handled independently.
- R2: In mode 0, each output channel is ((B<<3) + (F<<3)) / 2, narrowed by >>3.
- R3: In mode 1, each output channel is (B<<3) + (F<<3), saturated at 255 and then narrowed by >>3.
- R4: In mode 2, each output channel is (B<<3) − (F<<3), clamped at 0 and then narrowed by >>3.
- R5: In mode 3, each output channel is (B<<3) + ((F<<3)>>2), saturated at 255 and then narrowed by >>3. For example, background red 16 and foreground red 16 give 20.
- R6: Written bit 15 is (req_textured AND req_pixel[15]) OR req_set_mask. A flat color's bit 15 never reaches memory unless req_set_mask is high.
- R7: When req_check_mask is high and the stored pixel has bit 15 set, no write strobe is issued and the stored word is unchanged.
- R8: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is then low for exactly three cycles: the fetch, mix and store cycles. The write strobe comes in the store cycle, and a suppressed write still returns req_ready high in the fourth cycle. The read and write strobes are never high together.
- R9: When req_semi is low, the foreground color fields are written unchanged. A read is issued only if req_semi or req_check_mask is high.
- R10: During and right after reset, req_ready is high and both memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Stage idle and able to accept |
| req_addr | input | ADDR_W | Target pixel address |
| req_pixel | input | 16 | Foreground pixel (flat color or texel with mask bit) |
| req_textured | input | 1 | Foreground is a texel, so its bit 15 propagates |
| req_semi | input | 1 | Enable background mixing |
| req_mode | input | 2 | Blend mode 0..3 |
| req_set_mask | input | 1 | Force bit 15 high on write |
| req_check_mask | input | 1 | Protect pixels whose bit 15 is set |
| mem_rd_en | output | 1 | Read strobe, data valid on the next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Address for both read and write |
| mem_rd_data | input | 16 | Read data, one cycle after mem_rd_en |
| mem_wr_data | output | 16 | Data to write |

## Verification
The checker assumes that requests are sampled only when ready is high. It also assumes that the memory returns the addressed word exactly one cycle after the read strobe, with no stall. The bench's memory model follows that one-cycle read timing. The bench raises valid only when the stage is idle, and drops it again before the first busy cycle ends. The memory is preloaded only between requests, so every mask and inhibit decision the checker tracks belongs to the single request in flight.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    localparam int CH_W    = 5;
    localparam int EXP_SH  = 3;
    localparam int WIDE_W  = CH_W + EXP_SH;
    localparam int NUM_CH  = 3;
    localparam int PIX_W   = NUM_CH * CH_W + 1;

    typedef enum logic [1:0] {
        BM_AVG  = 2'd0,
        BM_ADD  = 2'd1,
        BM_SUB  = 2'd2,
        BM_QADD = 2'd3
    } blend_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MIX   = 2'd2,
        ST_STORE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic            mask;
        logic [CH_W-1:0] b;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] r;
    } pixel_t;

    typedef struct packed {
        logic        textured;
        logic        semi;
        blend_mode_e mode;
        logic        set_mask;
        logic        check_mask;
        pixel_t      fg;
    } req_ctl_t;

    function automatic logic [WIDE_W:0] widen(input logic [CH_W-1:0] c);
        return {1'b0, c, {EXP_SH{1'b0}}};
    endfunction

    function automatic logic [CH_W-1:0] chan_of(input pixel_t p, input int idx);
        case (idx)
            0:       return p.r;
            1:       return p.g;
            default: return p.b;
        endcase
    endfunction
endpackage

// File: rtl/pbw_chan_mix.sv
module pbw_chan_mix
    import pbw_pkg::*;
(
    input  blend_mode_e       mode,
    input  logic [CH_W-1:0]   bg_c,
    input  logic [CH_W-1:0]   fg_c,
    output logic [CH_W-1:0]   out_c
);
    logic [WIDE_W:0]   bw, fw, sum, qsum, diff;
    logic [WIDE_W-1:0] res;

    always_comb begin
        bw   = widen(bg_c);
        fw   = widen(fg_c);
        sum  = bw + fw;
        qsum = bw + (fw >> 2);
        diff = bw - fw;
        case (mode)
            BM_AVG:  res = sum[WIDE_W:1];
            BM_ADD:  res = sum[WIDE_W]  ? {WIDE_W{1'b1}} : sum[WIDE_W-1:0];
            BM_SUB:  res = (bw < fw)    ? {WIDE_W{1'b0}} : diff[WIDE_W-1:0];
            default: res = qsum[WIDE_W] ? {WIDE_W{1'b1}} : qsum[WIDE_W-1:0];
        endcase
        out_c = res[WIDE_W-1:EXP_SH];
    end
endmodule

// File: rtl/pbw_seq.sv
module pbw_seq
    import pbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_state_e state,
    output logic       idle
);
    seq_state_e nxt;

    always_comb begin
        case (state)
            ST_IDLE:  nxt = start ? ST_FETCH : ST_IDLE;
            ST_FETCH: nxt = ST_MIX;
            ST_MIX:   nxt = ST_STORE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign idle = (state == ST_IDLE);
endmodule

// File: rtl/pix_blend_wr.sv
module pix_blend_wr
    import pbw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_pixel,
    input  logic              req_textured,
    input  logic              req_semi,
    input  logic [1:0]        req_mode,
    input  logic              req_set_mask,
    input  logic              req_check_mask,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rd_data,
    output logic [15:0]       mem_wr_data
);
    seq_state_e        state;
    logic              idle, accept;
    logic [ADDR_W-1:0] addr_q;
    req_ctl_t          ctl_q;
    pixel_t            bg_pix, wr_q, next_pix;
    logic              inhib_q;
    logic [NUM_CH-1:0][CH_W-1:0] bg_ch, fg_ch, mix_ch;

    assign accept = req_valid && idle;

    pbw_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .state (state),
        .idle  (idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            ctl_q   <= '0;
            wr_q    <= '0;
            inhib_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q           <= req_addr;
                ctl_q.textured   <= req_textured;
                ctl_q.semi       <= req_semi;
                ctl_q.mode       <= blend_mode_e'(req_mode);
                ctl_q.set_mask   <= req_set_mask;
                ctl_q.check_mask <= req_check_mask;
                ctl_q.fg         <= pixel_t'(req_pixel);
            end
            if (state == ST_MIX) begin
                wr_q    <= next_pix;
                inhib_q <= ctl_q.check_mask && bg_pix.mask;
            end
        end
    end

    assign bg_pix = pixel_t'(mem_rd_data);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign bg_ch[c] = chan_of(bg_pix, c);
        assign fg_ch[c] = chan_of(ctl_q.fg, c);
        pbw_chan_mix u_mix (
            .mode  (ctl_q.mode),
            .bg_c  (bg_ch[c]),
            .fg_c  (fg_ch[c]),
            .out_c (mix_ch[c])
        );
    end

    always_comb begin
        next_pix   = ctl_q.fg;
        if (ctl_q.semi) begin
            next_pix.r = mix_ch[0];
            next_pix.g = mix_ch[1];
            next_pix.b = mix_ch[2];
        end
        next_pix.mask = (ctl_q.textured && ctl_q.fg.mask) || ctl_q.set_mask;
    end

    assign req_ready   = idle;
    assign mem_addr    = addr_q;
    assign mem_rd_en   = (state == ST_FETCH) && (ctl_q.semi || ctl_q.check_mask);
    assign mem_wr_en   = (state == ST_STORE) && !inhib_q;
    assign mem_wr_data = wr_q;
endmodule

// File: rtl/pbw_checks.sv
module pbw_checks #(
    parameter int ADDR_W = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [15:0] req_pixel,
    input logic        req_textured,
    input logic        req_semi,
    input logic        req_set_mask,
    input logic        req_check_mask,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [15:0] mem_rd_data,
    input logic [15:0] mem_wr_data
);
    logic sv_tex, sv_fgm, sv_semi, sv_set, sv_chk, rd_pend, blocked;
    logic acc;
    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            {sv_tex, sv_fgm, sv_semi, sv_set, sv_chk, rd_pend, blocked} <= '0;
        end else begin
            rd_pend <= mem_rd_en;
            if (acc) begin
                sv_tex  <= req_textured;
                sv_fgm  <= req_pixel[15];
                sv_semi <= req_semi;
                sv_set  <= req_set_mask;
                sv_chk  <= req_check_mask;
                blocked <= 1'b0;
            end else if (rd_pend && sv_chk && mem_rd_data[15]) begin
                blocked <= 1'b1;
            end
        end
    end

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        acc |=> !req_ready);
    p_ready_returns_r8: assert property (@(posedge clk) disable iff (rst)
        acc |-> ##4 req_ready);
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));
    p_write_last_r8: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> req_ready);
    p_set_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && (sv_set || (sv_tex && sv_fgm))) |-> mem_wr_data[15]);
    p_clear_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !sv_set && !(sv_tex && sv_fgm)) |-> !mem_wr_data[15]);
    p_protect_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> !blocked);
    p_read_needed_r9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (sv_semi || sv_chk));
endmodule

bind pix_blend_wr pbw_checks #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_pixel      (req_pixel),
    .req_textured   (req_textured),
    .req_semi       (req_semi),
    .req_set_mask   (req_set_mask),
    .req_check_mask (req_check_mask),
    .mem_rd_en      (mem_rd_en),
    .mem_wr_en      (mem_wr_en),
    .mem_rd_data    (mem_rd_data),
    .mem_wr_data    (mem_wr_data)
);

// File: tb/pix_blend_wr_tb_top.sv
module pix_blend_wr_tb_top;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_pixel = '0;
    logic          req_textured = 1'b0, req_semi = 1'b0;
    logic [1:0]    req_mode = '0;
    logic          req_set_mask = 1'b0, req_check_mask = 1'b0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rd_data, mem_wr_data;

    logic [15:0]   fb [0:DEPTH-1];
    logic          pre_we = 1'b0, cnt_clr = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [15:0]   pre_data = '0;
    int            n_rd, n_wr;
    int            tests = 0, fails = 0;

    always #10 clk = ~clk;

    pix_blend_wr #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_pixel(req_pixel), .req_textured(req_textured),
        .req_semi(req_semi), .req_mode(req_mode), .req_set_mask(req_set_mask),
        .req_check_mask(req_check_mask), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .mem_wr_data(mem_wr_data)
    );

    always @(posedge clk) begin
        if (pre_we) fb[pre_addr] <= pre_data;
        else if (mem_wr_en) fb[mem_addr] <= mem_wr_data;
        if (mem_rd_en) mem_rd_data <= fb[mem_addr];
        if (cnt_clr) begin
            n_rd <= 0;
            n_wr <= 0;
        end else begin
            n_rd <= n_rd + (mem_rd_en ? 1 : 0);
            n_wr <= n_wr + (mem_wr_en ? 1 : 0);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [15:0] bg, input logic [15:0] fg,
                                          input logic tex, input logic semi,
                                          input logic [1:0] mode, input logic setm);
        logic [15:0] res = '0;
        for (int c = 0; c < 3; c++) begin
            int b = ((bg >> (5 * c)) & 31) * 8;
            int f = ((fg >> (5 * c)) & 31) * 8;
            int r;
            case (mode)
                2'd0: r = (b + f) / 2;
                2'd1: r = (b + f > 255) ? 255 : b + f;
                2'd2: r = (b - f < 0) ? 0 : b - f;
                default: r = (b + f / 4 > 255) ? 255 : b + f / 4;
            endcase
            if (!semi) r = f;
            res = res | 16'((r / 8) << (5 * c));
        end
        res[15] = (tex & fg[15]) | setm;
        return res;
    endfunction

    task automatic run_req(input logic [AW-1:0] a, input logic [15:0] bg, input logic [15:0] fg,
                           input logic tex, input logic semi, input logic [1:0] mode,
                           input logic setm, input logic chk, input string tag);
        logic [3:0]  rdy;
        logic [15:0] exp;
        logic        blocked;
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = bg; cnt_clr = 1'b1;
        @(negedge clk);
        pre_we = 1'b0; cnt_clr = 1'b0;
        check("R8 idle before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = a; req_pixel = fg; req_textured = tex;
        req_semi = semi; req_mode = mode; req_set_mask = setm; req_check_mask = chk;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            rdy[i] = req_ready;
        end
        blocked = chk && bg[15];
        exp = blocked ? bg : model(bg, fg, tex, semi, mode, setm);
        check(tag, {16'd0, fb[a]}, {16'd0, exp});
        check("R6 mask bit", {31'd0, fb[a][15]}, {31'd0, exp[15]});
        check("R8 ready pattern", {28'd0, rdy}, 32'b1000);
        check("R7 write count", n_wr, blocked ? 0 : 1);
        check("R9 read count", n_rd, (semi || chk) ? 1 : 0);
    endtask

    function automatic string mode_tag(input logic semi, input logic [1:0] m, input logic blk);
        if (blk) return "R7";
        if (!semi) return "R9";
        case (m)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 ready in reset", {31'd0, req_ready}, 32'd1);
        check("R10 strobes in reset", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R10 strobes after reset", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);

        // masked texel over red-16 background, all four modes
        run_req(6'd3, 16'h0010, 16'h8364, 1, 1, 2'd0, 0, 0, "R2 texel");
        check("R2 texel word", {16'd0, fb[3]}, 32'h81AA);
        run_req(6'd3, 16'h0010, 16'h8364, 1, 1, 2'd1, 0, 0, "R3 texel");
        check("R3 texel word", {16'd0, fb[3]}, 32'h8374);
        run_req(6'd3, 16'h0010, 16'h8364, 1, 1, 2'd2, 0, 0, "R4 texel");
        check("R4 texel word", {16'd0, fb[3]}, 32'h800C);
        run_req(6'd3, 16'h0010, 16'h8364, 1, 1, 2'd3, 0, 0, "R5 texel");
        check("R5 texel word", {16'd0, fb[3]}, 32'h80D1);
        run_req(6'd7, 16'h0010, 16'h0010, 0, 1, 2'd3, 0, 0, "R5 quarter add");
        check("R5 16+16/4", {16'd0, fb[7]}, 32'h0014);
        run_req(6'd7, 16'h0010, 16'h0010, 0, 1, 2'd1, 0, 0, "R3 saturate");
        check("R3 saturated", {16'd0, fb[7]}, 32'h001F);
        run_req(6'd7, 16'h0010, 16'h001F, 0, 1, 2'd2, 0, 0, "R4 clamp");
        check("R4 clamped", {16'd0, fb[7]}, 32'h0000);
        run_req(6'd9, 16'h0010, 16'h0010, 0, 1, 2'd0, 1, 0, "R6 set mask");
        check("R6 forced mask", {16'd0, fb[9]}, 32'h8010);
        run_req(6'd9, 16'h0000, 16'h8010, 0, 0, 2'd0, 0, 0, "R6 flat mask dropped");
        check("R6 flat bit15", {16'd0, fb[9]}, 32'h0010);
        run_req(6'd11, 16'h8010, 16'h7FFF, 0, 1, 2'd1, 1, 1, "R7 protected");
        check("R7 untouched", {16'd0, fb[11]}, 32'h8010);
        run_req(6'd12, 16'h1234, 16'h0C41, 0, 0, 2'd2, 0, 0, "R1 field positions");
        check("R1 fields", {16'd0, fb[12]}, 32'h0C41);

        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a;
            logic [15:0]   bg, fg;
            logic          tex, semi, setm, chk;
            logic [1:0]    m;
            a = AW'($urandom); bg = 16'($urandom); fg = 16'($urandom);
            tex = 1'($urandom); semi = ($urandom % 4) != 0; m = 2'($urandom);
            setm = ($urandom % 4) == 0; chk = 1'($urandom);
            run_req(a, bg, fg, tex, semi, m, setm, chk, mode_tag(semi, m, chk && bg[15]));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule